// File: doc/BRIEF.md
# Float to integer converter

This block turns a single-precision IEEE-754 bit pattern into a 32-bit integer, either unsigned or two's-complement signed. A two-bit mode selects how a fractional part is rounded, and a truncate input overrides that mode with round-toward-zero for one conversion. Along with the integer it reports three flags: the operation was invalid, the result is inexact, and the input was a subnormal.

Each conversion is accepted when `in_valid` is high at a clock edge. Its result and flags appear on the outputs one cycle later, together with `out_valid`. The outputs keep the last result while no new conversion arrives. Out-of-range values, NaN and infinities saturate by rules that differ between signed and unsigned conversion. Magnitudes below one are resolved by a fixed table per rounding mode. Negative inputs to an unsigned conversion never return a nonzero value.

Top module: `f2i_conv`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle. Result and flags update only when `in_valid` was high, and otherwise hold. After reset all outputs are 0.
- R2: `out_denorm` is 1 exactly when the input biased exponent is 0 and its fraction is nonzero.
- R3: A NaN (exponent 255, fraction nonzero) yields 0 with invalid set, in both signed and unsigned conversion. Unsigned conversion treats a NaN as negative.
- R4: Unsigned conversion with biased exponent 159 or more yields 0 for negative inputs and 0xFFFFFFFF otherwise, with invalid set and inexact clear.
- R5: Signed conversion of a non-NaN with biased exponent 158 or more yields 0x7FFFFFFF, or 0x80000000 if negative, with invalid set.
- R6: For magnitudes of one or more in range, mode 0 rounds to nearest with ties to even, mode 1 toward +infinity, mode 2 toward −infinity and mode 3 toward zero. Inexact is set when a nonzero fraction was discarded.
- R7: `in_trunc` high forces mode 3 whatever `in_rmode` holds.
- R8: Unsigned conversion of a negative value whose magnitude rounds to nonzero yields 0 with invalid set and inexact clear. A rounding carry beyond 0xFFFFFFFF sets invalid, and a signed rounded magnitude past its limit clamps to that limit with invalid set.
- R9: A nonzero magnitude below one always sets inexact, except an unsigned negative case that sets invalid instead. It gives 1 in mode 1 if positive, −1 in signed mode 2 if negative, and ±1 in mode 0 only if strictly above one half (exactly one half gives 0). Every other case gives 0. In unsigned conversion, a negative input under mode 2, or above one half under mode 0, sets invalid instead of inexact.
- R10: A signed negative result is the two's-complement negation of the rounded magnitude.
- R11: A zero input of either sign yields 0 with no flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A conversion is presented this cycle |
| in_bits | input | 32 | Single-precision input pattern |
| in_signed | input | 1 | 1 selects signed result, 0 unsigned |
| in_rmode | input | 2 | Rounding mode: 0 nearest-even, 1 up, 2 down, 3 toward zero |
| in_trunc | input | 1 | Force toward-zero rounding |
| out_valid | output | 1 | Result below is new this cycle |
| out_int | output | 32 | Integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Subnormal-input flag |

## Verification
The bound checker watches, on every accepted input, the valid pipeline and hold behaviour, the subnormal flag, signed NaN and signed saturation. It also covers unsigned saturation, the rule that negative unsigned inputs give 0, the toward-zero result below one, and silent zeros. Ties-to-even, directed increments across a fraction, two's-complement negation and the full below-one table per mode depend on arithmetic value. Only the bench's directed corners and its random patterns, compared against a reference function, show these.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_UP   = 2'd1,
    RND_DOWN = 2'd2,
    RND_ZERO = 2'd3
  } rnd_e;

  typedef struct packed {
    logic neg;
    logic nan;
    logic zero;
    logic denorm;
    logic frac_nz;
  } cls_t;

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] bits_i,
  output f2i_pkg::cls_t         cls_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [FRAC_W:0]       sig_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero;
  logic              exp_full;

  assign exp_f    = bits_i[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f   = bits_i[FRAC_W-1:0];
  assign exp_zero = (exp_f == '0);
  assign exp_full = (exp_f == '1);

  always_comb begin
    cls_o.neg     = bits_i[EXP_W+FRAC_W];
    cls_o.frac_nz = (frac_f != '0);
    cls_o.nan     = exp_full && cls_o.frac_nz;
    cls_o.zero    = exp_zero && !cls_o.frac_nz;
    cls_o.denorm  = exp_zero && cls_o.frac_nz;
  end

  assign exp_o = exp_f;
  // hidden bit present only for normal encodings
  assign sig_o = {!exp_zero, frac_f};
endmodule

// File: rtl/f2i_shift_round.sv
module f2i_shift_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input  logic [FRAC_W:0]    sig_i,
  input  logic [EXP_W-1:0]   exp_i,
  input  logic               neg_i,
  input  f2i_pkg::rnd_e      mode_i,
  output logic [INT_W-1:0]   mag_o,
  output logic               rem_nz_o,
  output logic               bump_o
);
  import f2i_pkg::*;

  localparam int SH_W   = $clog2(INT_W);
  localparam int WIDE_W = FRAC_W + INT_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] BIAS_E = EXP_W'(BIAS);

  logic [SH_W-1:0]   shamt;
  logic [EXP_W-1:0]  exp_off;
  logic [WIDE_W-1:0] wide;
  logic [FRAC_W-1:0] rem;
  logic              half_bit;
  logic              below_half_nz;

  // Only meaningful when the exponent lies in the in-range window.
  assign exp_off = exp_i - BIAS_E;
  assign shamt   = SH_W'(exp_off);
  assign wide    = {{(INT_W-1){1'b0}}, sig_i} << shamt;
  assign mag_o   = wide[WIDE_W-1:FRAC_W];
  assign rem     = wide[FRAC_W-1:0];

  assign half_bit      = rem[FRAC_W-1];
  assign below_half_nz = (rem[FRAC_W-2:0] != '0);
  assign rem_nz_o      = half_bit || below_half_nz;

  always_comb begin
    bump_o = 1'b0;
    unique case (mode_i)
      RND_NEAR: bump_o = half_bit && (below_half_nz || mag_o[0]);
      RND_UP:   bump_o = rem_nz_o && !neg_i;
      RND_DOWN: bump_o = rem_nz_o && neg_i;
      RND_ZERO: bump_o = 1'b0;
      default:  bump_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/f2i_resolve.sv
module f2i_resolve #(
  parameter int EXP_W = 8,
  parameter int INT_W = 32
) (
  input  logic               signed_i,
  input  f2i_pkg::cls_t      cls_i,
  input  logic [EXP_W-1:0]   exp_i,
  input  f2i_pkg::rnd_e      mode_i,
  input  logic [INT_W-1:0]   mag_i,
  input  logic               rem_nz_i,
  input  logic               bump_i,
  output logic [INT_W-1:0]   res_o,
  output logic               invalid_o,
  output logic               inexact_o
);
  import f2i_pkg::*;

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] E_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] E_HALF = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] E_ULIM = EXP_W'(BIAS + INT_W);
  localparam logic [EXP_W-1:0] E_SLIM = EXP_W'(BIAS + INT_W - 1);
  localparam logic [INT_W-1:0] ALL1   = '1;
  localparam logic [INT_W-1:0] ONE    = INT_W'(1);
  localparam logic [INT_W-1:0] SMAX   = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SMIN   = {1'b1, {(INT_W-1){1'b0}}};

  logic             in_range;
  logic             above_half;
  logic [INT_W:0]   s_sum;
  logic [INT_W:0]   s_lim;
  logic [INT_W:0]   s_mag;
  logic [INT_W-1:0] u_mag;
  logic             u_carry_ovf;
  logic             u_neg;

  assign in_range   = (exp_i >= E_ONE);
  assign above_half = (exp_i == E_HALF) && cls_i.frac_nz;
  assign u_neg      = cls_i.neg || cls_i.nan;

  // signed rounded magnitude and its clamp limit
  assign s_sum = {1'b0, mag_i} + {{INT_W{1'b0}}, bump_i};
  assign s_lim = {1'b0, SMAX} + {{INT_W{1'b0}}, cls_i.neg};

  always_comb begin
    if (s_sum > s_lim) s_mag = s_lim;
    else               s_mag = s_sum;
  end

  // unsigned rounded magnitude, carry past the top is refused
  always_comb begin
    u_carry_ovf = bump_i && (mag_i == ALL1);
    if (bump_i && !u_carry_ovf) u_mag = mag_i + ONE;
    else                        u_mag = mag_i;
  end

  always_comb begin
    res_o     = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    if (signed_i) begin
      if (cls_i.nan) begin
        invalid_o = 1'b1;
      end else if (exp_i >= E_SLIM) begin
        res_o     = cls_i.neg ? SMIN : SMAX;
        invalid_o = 1'b1;
      end else if (in_range) begin
        if (s_sum > s_lim) invalid_o = 1'b1;
        else               inexact_o = rem_nz_i;
        res_o = cls_i.neg ? (~s_mag[INT_W-1:0] + ONE) : s_mag[INT_W-1:0];
      end else if (!cls_i.zero) begin
        inexact_o = 1'b1;
        unique case (mode_i)
          RND_NEAR: if (above_half) res_o = cls_i.neg ? ALL1 : ONE;
          RND_UP:   if (!cls_i.neg) res_o = ONE;
          RND_DOWN: if (cls_i.neg)  res_o = ALL1;
          default:  res_o = '0;
        endcase
      end
    end else begin
      if (exp_i >= E_ULIM) begin
        res_o     = u_neg ? '0 : ALL1;
        invalid_o = 1'b1;
      end else if (in_range) begin
        invalid_o = u_carry_ovf;
        if (u_neg && (u_mag != '0)) begin
          invalid_o = 1'b1;
        end else begin
          res_o     = u_mag;
          inexact_o = rem_nz_i;
        end
      end else if (!cls_i.zero) begin
        unique case (mode_i)
          RND_NEAR: begin
            if (above_half && u_neg) invalid_o = 1'b1;
            else begin
              inexact_o = 1'b1;
              if (above_half) res_o = ONE;
            end
          end
          RND_UP: begin
            inexact_o = 1'b1;
            if (!u_neg) res_o = ONE;
          end
          RND_DOWN: begin
            if (u_neg) invalid_o = 1'b1;
            else       inexact_o = 1'b1;
          end
          default: inexact_o = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv #(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] in_bits,
  input  logic                  in_signed,
  input  logic [1:0]            in_rmode,
  input  logic                  in_trunc,
  output logic                  out_valid,
  output logic [INT_W-1:0]      out_int,
  output logic                  out_invalid,
  output logic                  out_inexact,
  output logic                  out_denorm
);
  import f2i_pkg::*;

  logic rst_meta_n;
  logic rst_sync_n;

  // asynchronous assertion, release aligned to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  rnd_e             eff_mode;
  cls_t             cls;
  logic [EXP_W-1:0] exp_v;
  logic [FRAC_W:0]  sig_v;
  logic [INT_W-1:0] mag_v;
  logic             rem_nz_v;
  logic             bump_v;
  logic [INT_W-1:0] res_v;
  logic             inv_v;
  logic             inx_v;

  assign eff_mode = in_trunc ? RND_ZERO : rnd_e'(in_rmode);

  f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
    .bits_i (in_bits),
    .cls_o  (cls),
    .exp_o  (exp_v),
    .sig_o  (sig_v)
  );

  f2i_shift_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_shift_round (
    .sig_i    (sig_v),
    .exp_i    (exp_v),
    .neg_i    (cls.neg),
    .mode_i   (eff_mode),
    .mag_o    (mag_v),
    .rem_nz_o (rem_nz_v),
    .bump_o   (bump_v)
  );

  f2i_resolve #(.EXP_W(EXP_W), .INT_W(INT_W)) u_resolve (
    .signed_i  (in_signed),
    .cls_i     (cls),
    .exp_i     (exp_v),
    .mode_i    (eff_mode),
    .mag_i     (mag_v),
    .rem_nz_i  (rem_nz_v),
    .bump_i    (bump_v),
    .res_o     (res_v),
    .invalid_o (inv_v),
    .inexact_o (inx_v)
  );

  logic             valid_d;
  logic [INT_W-1:0] int_d;
  logic             inv_d;
  logic             inx_d;
  logic             den_d;

  always_comb begin
    valid_d = in_valid;
    int_d   = res_v;
    inv_d   = inv_v;
    inx_d   = inx_v;
    den_d   = cls.denorm;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_denorm  <= 1'b0;
    end else if (in_valid) begin
      out_int     <= int_d;
      out_invalid <= inv_d;
      out_inexact <= inx_d;
      out_denorm  <= den_d;
    end
  end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  arst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] in_bits,
  input logic                  in_signed,
  input logic [1:0]            in_rmode,
  input logic                  in_trunc,
  input logic                  out_valid,
  input logic [INT_W-1:0]      out_int,
  input logic                  out_invalid,
  input logic                  out_inexact,
  input logic                  out_denorm
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] C_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] C_ULIM = EXP_W'(BIAS + INT_W);
  localparam logic [EXP_W-1:0] C_SLIM = EXP_W'(BIAS + INT_W - 1);
  localparam logic [INT_W-1:0] C_SMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] C_SMIN = {1'b1, {(INT_W-1){1'b0}}};

  logic [EXP_W-1:0]  c_exp;
  logic [FRAC_W-1:0] c_frac;
  logic              c_neg;
  logic              c_nan;

  assign c_exp  = in_bits[EXP_W+FRAC_W-1:FRAC_W];
  assign c_frac = in_bits[FRAC_W-1:0];
  assign c_neg  = in_bits[EXP_W+FRAC_W];
  assign c_nan  = (c_exp == '1) && (c_frac != '0);

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!arst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !in_valid |=> !out_valid);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !in_valid |=> ($stable(out_int) && $stable(out_invalid) &&
                   $stable(out_inexact) && $stable(out_denorm)));
  assert_denorm_R2: assert property (@(posedge clk) disable iff (!arst_n)
    in_valid |=> (out_denorm == $past((c_exp == '0) && (c_frac != '0))));
  assert_nan_signed_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && in_signed && c_nan) |=> (out_int == '0 && out_invalid));
  assert_unsigned_sat_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && !in_signed && (c_exp >= C_ULIM)) |=> (out_invalid && !out_inexact));
  assert_signed_sat_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && in_signed && !c_nan && (c_exp >= C_SLIM) && !c_neg)
      |=> (out_int == C_SMAX && out_invalid));
  assert_signed_sat_neg_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && in_signed && !c_nan && (c_exp >= C_SLIM) && c_neg)
      |=> (out_int == C_SMIN && out_invalid));
  assert_rtz_small_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && (in_trunc || in_rmode == 2'd3) && (c_exp < C_ONE))
      |=> (out_int == '0));
  assert_unsigned_neg_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && !in_signed && c_neg) |=> (out_int == '0));
  assert_zero_R11: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && (in_bits[EXP_W+FRAC_W-1:0] == '0))
      |=> (out_int == '0 && !out_invalid && !out_inexact && !out_denorm));
endmodule

bind f2i_conv f2i_conv_chk #(.INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .arst_n      (rst_sync_n),
  .in_valid    (in_valid),
  .in_bits     (in_bits),
  .in_signed   (in_signed),
  .in_rmode    (in_rmode),
  .in_trunc    (in_trunc),
  .out_valid   (out_valid),
  .out_int     (out_int),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact),
  .out_denorm  (out_denorm)
);

// File: tb/f2i_conv_tb.sv
`timescale 1ns/1ps
module f2i_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_bits;
  logic        in_signed;
  logic [1:0]  in_rmode;
  logic        in_trunc;
  logic        out_valid;
  logic [31:0] out_int;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_denorm;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  f2i_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .in_signed(in_signed), .in_rmode(in_rmode), .in_trunc(in_trunc),
    .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_denorm(out_denorm)
  );

  // Reference from the requirements: {denorm, inexact, invalid, result}
  function automatic logic [34:0] ref_conv(input logic [31:0] b, input bit sgn,
                                           input logic [1:0] md_in, input bit trunc);
    int unsigned e = b[30:23];
    longint unsigned fr23 = b[22:0];
    bit neg = b[31];
    bit nan = (e == 255) && (fr23 != 0);
    bit den = (e == 0) && (fr23 != 0);
    bit nz = (e != 0) || (fr23 != 0);
    logic [1:0] md = trunc ? 2'd3 : md_in;
    bit above_half = (e == 126) && (fr23 != 0);
    logic [31:0] r = 0;
    bit inv = 0, inx = 0;
    longint unsigned mant = ((e != 0) ? 64'h800000 : 64'h0) | fr23;
    longint unsigned v, ip, fr, lim;
    bit up;
    if (sgn) begin
      if (nan) inv = 1;
      else if (e >= 158) begin r = neg ? 32'h80000000 : 32'h7FFFFFFF; inv = 1; end
      else if (e >= 127) begin
        v = mant << (e - 127); ip = v >> 23; fr = v & 64'h7FFFFF;
        case (md)
          2'd0: up = (fr > 64'h400000) || (fr == 64'h400000 && ip[0]);
          2'd1: up = (fr != 0) && !neg;
          2'd2: up = (fr != 0) && neg;
          default: up = 0;
        endcase
        ip = ip + up;
        lim = neg ? 64'h80000000 : 64'h7FFFFFFF;
        if (ip > lim) begin ip = lim; inv = 1; end else inx = (fr != 0);
        r = neg ? (32'h0 - ip[31:0]) : ip[31:0];
      end else if (nz) begin
        inx = 1;
        if (md == 2'd0 && above_half) r = neg ? 32'hFFFFFFFF : 32'd1;
        if (md == 2'd1 && !neg) r = 32'd1;
        if (md == 2'd2 && neg) r = 32'hFFFFFFFF;
      end
    end else begin
      if (nan) neg = 1;
      if (e >= 159) begin r = neg ? 32'h0 : 32'hFFFFFFFF; inv = 1; end
      else if (e >= 127) begin
        v = mant << (e - 127); ip = v >> 23; fr = v & 64'h7FFFFF;
        case (md)
          2'd0: up = (fr > 64'h400000) || (fr == 64'h400000 && ip[0]);
          2'd1: up = (fr != 0) && !neg;
          2'd2: up = (fr != 0) && neg;
          default: up = 0;
        endcase
        if (up) begin
          if (ip < 64'hFFFFFFFF) ip = ip + 1; else inv = 1;
        end
        if (ip != 0 && neg) inv = 1;
        else begin r = ip[31:0]; inx = (fr != 0); end
      end else if (nz) begin
        case (md)
          2'd0: if (above_half && neg) inv = 1;
                else begin inx = 1; if (above_half) r = 32'd1; end
          2'd1: begin inx = 1; if (!neg) r = 32'd1; end
          2'd2: if (neg) inv = 1; else inx = 1;
          default: inx = 1;
        endcase
      end
    end
    return {den, inx, inv, r};
  endfunction

  task automatic compare(input string tag, input logic [31:0] er, input bit ei,
                         input bit ex, input bit ed);
    checks++;
    if (out_valid !== 1'b1 || out_int !== er || out_invalid !== ei ||
        out_inexact !== ex || out_denorm !== ed) begin
      errors++;
      $display("FAIL %s in=%h: actual v=%b int=%h inv=%b inx=%b den=%b expected v=1 int=%h inv=%b inx=%b den=%b",
               tag, in_bits, out_valid, out_int, out_invalid, out_inexact, out_denorm,
               er, ei, ex, ed);
    end
  endtask

  task automatic drive(input logic [31:0] b, input bit s, input logic [1:0] m, input bit t);
    @(negedge clk);
    in_valid = 1'b1; in_bits = b; in_signed = s; in_rmode = m; in_trunc = t;
    @(negedge clk);
  endtask

  task automatic direct(input string tag, input logic [31:0] b, input bit s,
                        input logic [1:0] m, input bit t, input logic [31:0] er,
                        input bit ei, input bit ex, input bit ed);
    drive(b, s, m, t);
    compare(tag, er, ei, ex, ed);
    in_valid = 1'b0;
  endtask

  task automatic modeled(input string tag, input logic [31:0] b, input bit s,
                         input logic [1:0] m, input bit t);
    logic [34:0] exp_v;
    exp_v = ref_conv(b, s, m, t);
    drive(b, s, m, t);
    compare(tag, exp_v[31:0], exp_v[32], exp_v[33], exp_v[34]);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    logic [31:0] rb;
    in_valid = 0; in_bits = 0; in_signed = 0; in_rmode = 0; in_trunc = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    checks++;
    if (out_valid !== 0 || out_int !== 0 || out_invalid !== 0 || out_inexact !== 0 || out_denorm !== 0) begin
      errors++;
      $display("FAIL R1 reset: actual v=%b int=%h expected v=0 int=00000000", out_valid, out_int);
    end

    // R6 rounding, signed and unsigned
    direct("R6 2.5 near", 32'h40200000, 1, 0, 0, 32'd2, 0, 1, 0);
    direct("R6 3.5 near", 32'h40600000, 1, 0, 0, 32'd4, 0, 1, 0);
    direct("R6 1.5 up unsigned", 32'h3FC00000, 0, 1, 0, 32'd2, 0, 1, 0);
    direct("R6 1.0 up exact", 32'h3F800000, 1, 1, 0, 32'd1, 0, 0, 0);
    direct("R6 large exact", 32'h4B000001, 0, 0, 0, 32'd8388609, 0, 0, 0);
    // R10 negation
    direct("R10 -2.5 near", 32'hC0200000, 1, 0, 0, 32'hFFFFFFFE, 0, 1, 0);
    direct("R10 -2.5 down", 32'hC0200000, 1, 2, 0, 32'hFFFFFFFD, 0, 1, 0);
    direct("R10 -2.5 up", 32'hC0200000, 1, 1, 0, 32'hFFFFFFFE, 0, 1, 0);
    // R7 truncate override
    direct("R7 2.7 trunc over up", 32'h402CCCCD, 1, 1, 1, 32'd2, 0, 1, 0);
    direct("R7 -0.75 trunc over near", 32'hBF400000, 1, 0, 1, 32'd0, 0, 1, 0);
    // R8 unsigned negatives
    direct("R8 -1.5 unsigned near", 32'hBFC00000, 0, 0, 0, 32'd0, 1, 0, 0);
    direct("R8 -1.2 unsigned zero", 32'hBF99999A, 0, 3, 0, 32'd0, 1, 0, 0);
    // R9 below one
    direct("R9 0.5 near tie", 32'h3F000000, 1, 0, 0, 32'd0, 0, 1, 0);
    direct("R9 0.75 near", 32'h3F400000, 1, 0, 0, 32'd1, 0, 1, 0);
    direct("R9 -0.75 near signed", 32'hBF400000, 1, 0, 0, 32'hFFFFFFFF, 0, 1, 0);
    direct("R9 0.3 up unsigned", 32'h3E99999A, 0, 1, 0, 32'd1, 0, 1, 0);
    direct("R9 -0.3 down signed", 32'hBE99999A, 1, 2, 0, 32'hFFFFFFFF, 0, 1, 0);
    direct("R9 -0.75 near unsigned", 32'hBF400000, 0, 0, 0, 32'd0, 1, 0, 0);
    direct("R9 -0.3 down unsigned", 32'hBE99999A, 0, 2, 0, 32'd0, 1, 0, 0);
    direct("R9 -0.3 up unsigned", 32'hBE99999A, 0, 1, 0, 32'd0, 0, 1, 0);
    // R5 / R4 range limits
    direct("R5 2^31 signed", 32'h4F000000, 1, 0, 0, 32'h7FFFFFFF, 1, 0, 0);
    direct("R5 -2^31 signed", 32'hCF000000, 1, 0, 0, 32'h80000000, 1, 0, 0);
    direct("R5 -inf signed", 32'hFF800000, 1, 0, 0, 32'h80000000, 1, 0, 0);
    direct("R4 2^31 unsigned exact", 32'h4F000000, 0, 0, 0, 32'h80000000, 0, 0, 0);
    direct("R4 2^32 unsigned", 32'h4F800000, 0, 0, 0, 32'hFFFFFFFF, 1, 0, 0);
    direct("R4 +inf unsigned", 32'h7F800000, 0, 2, 0, 32'hFFFFFFFF, 1, 0, 0);
    direct("R4 -2^40 unsigned", 32'hD3800000, 0, 0, 0, 32'h0, 1, 0, 0);
    // R3 NaN
    direct("R3 qnan signed", 32'h7FC00000, 1, 0, 0, 32'h0, 1, 0, 0);
    direct("R3 snan unsigned", 32'h7F800001, 0, 1, 0, 32'h0, 1, 0, 0);
    // R2 subnormal, R11 zero
    direct("R2 denorm near", 32'h00000001, 1, 0, 0, 32'h0, 0, 1, 1);
    direct("R2 denorm up", 32'h00000001, 1, 1, 0, 32'd1, 0, 1, 1);
    direct("R11 +0", 32'h00000000, 0, 1, 0, 32'h0, 0, 0, 0);
    direct("R11 -0", 32'h80000000, 1, 2, 0, 32'h0, 0, 0, 0);

    // R1 hold while idle
    direct("R1 before idle", 32'h41200000, 1, 0, 0, 32'd10, 0, 0, 0);
    held = out_int;
    @(negedge clk);
    in_valid = 0; in_bits = 32'h7FC00000; in_signed = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_int !== held || out_invalid !== 0) begin
      errors++;
      $display("FAIL R1 hold: actual v=%b int=%h inv=%b expected v=0 int=%h inv=0",
               out_valid, out_int, out_invalid, held);
    end

    // R6 R8 R9 R10 random patterns against the reference
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 3000; i++) begin
      rb = $urandom;
      if (($urandom % 10) < 8) rb[30:23] = 8'(118 + ($urandom % 44));
      if (($urandom % 16) == 0) rb[22:0] = 23'h400000 << ($urandom % 3);
      modeled("R6 random", rb, 1'($urandom), 2'($urandom), (($urandom % 8) == 0));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule